// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block sits beside a small processor core and decides, on every clock, whether the core should take a hardware interrupt. It does not compute vectors, save status or switch register sets. It only looks at the incoming requests and the current status fields, and reports two things. The first is a one-cycle take pulse. The second is a flag telling the core that some request is active, so that the core can leave an idle state.

A build-time parameter selects one of two forms.

- **Line form.** The unit samples a bank of level-sensitive lines into a pending register and holds a software-written enable register. It fires when the global enable is on and some line is both pending and enabled.
- **Bundle form.** The unit takes a single request from an external controller. The request carries a non-maskable flag, a priority level and a target register-set number. These are weighed against the status interrupt level, the current register set, the re-entry enable and the non-maskable-in-progress bit.

Top module: `irq_accept_unit`

## Requirements
- R1: In line form, `pend_rdata` bit i equals the value `irq_lines` bit i had at the previous rising clock edge: set while the line is high, cleared while it is low.
- R2: In line form, when `en_wr` is 1 at a clock edge, `en_rdata` shows `en_wdata` from the next cycle on. The enable value is kept while `en_wr` is 0.
- R3: In line form, the take pulse is produced only when `st_gie` is 1 and `pend_rdata & en_rdata` is nonzero. Enabled-but-not-pending lines never cause it, and pending-but-not-enabled lines never cause it.
- R4: `take_irq` is high for exactly one cycle. It rises in the cycle after the acceptance condition becomes true and stays low while that condition stays true.
- R5: In bundle form, a request with `req_nmi`=1 is taken when `st_nmi_busy` is 0, whatever the level, register-set and enable fields are. It is refused when `st_nmi_busy` is 1.
- R6: In bundle form, a maskable request (`req_nmi`=0) is refused when `st_gie` is 0.
- R7: In bundle form, a maskable request is refused when `req_level` is less than or equal to `st_level`. This includes the equal case.
- R8: In bundle form, a maskable request that passes R6 and R7 is taken when `req_rset` differs from `st_crs`. When the two are equal, it is taken only if `st_rsie` is 1.
- R9: `work_pending` is 1 whenever a request is active, even while acceptance is blocked. In line form this means any bit of `pend_rdata` is set. In bundle form it means `req_valid` is 1.
- R10: Synchronous active-high `rst` clears the pending register, the enable register and `take_irq` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines (line form) |
| en_wr | input | 1 | Write strobe for the enable register (line form) |
| en_wdata | input | NUM_LINES | New enable value |
| en_rdata | output | NUM_LINES | Current enable register (zero in bundle form) |
| pend_rdata | output | NUM_LINES | Current pending register, read-only (zero in bundle form) |
| req_valid | input | 1 | External request present (bundle form) |
| req_nmi | input | 1 | External request is non-maskable |
| req_level | input | LEVEL_W | Requested priority level |
| req_rset | input | RSET_W | Requested register-set number |
| st_gie | input | 1 | Status global interrupt enable |
| st_nmi_busy | input | 1 | Status: non-maskable handler in progress |
| st_rsie | input | 1 | Status: re-entry into the current register set allowed |
| st_level | input | LEVEL_W | Status current interrupt level |
| st_crs | input | RSET_W | Status current register set |
| take_irq | output | 1 | One-cycle take-interrupt pulse |
| work_pending | output | 1 | Some request is active |

## Verification
The bundle form is driven from a table of request and status combinations. Each row isolates one gate:

- the non-maskable path with every other gate closed, and with the busy bit set;
- the global enable turned off;
- the level equal to, one above, and at the top of its range;
- the register set differing, or equal with re-entry off and on;
- a maskable request with the busy bit set, showing that bit does not gate maskable requests.

The line form is tried with:

- an enabled line that is not pending;
- a pending line with the global enable off;
- a release of the global enable while a line is pending, which shows the single-cycle pulse;
- the top line index.

A mid-run reset shows that the stored state is cleared.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic {
        MODE_LINES  = 1'b0,
        MODE_BUNDLE = 1'b1
    } accept_mode_e;

    typedef struct packed {
        logic seen;
        logic take;
    } pulse_state_t;

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic                 wr_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] en_o,
    output logic                 hit_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] en;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = lines_i;
        if (wr_i) begin
            bank_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend_o = bank_q.pend;
    assign en_o   = bank_q.en;
    assign hit_o  = |(bank_q.pend & bank_q.en);

    // R1: pending tracks the line level of the previous cycle
    assert_pend_follow_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_o == $past(lines_i));

    // R2: a write lands in the enable register
    assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> en_o == $past(wdata_i));

    // R2: without a write the enable register holds
    assert_en_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_i && !$past(rst) |=> $stable(en_o));

endmodule

// File: rtl/irq_bundle_judge.sv
module irq_bundle_judge #(
    parameter int LEVEL_W = 6,
    parameter int RSET_W  = 6
) (
    input  logic               valid_i,
    input  logic               nmi_i,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [RSET_W-1:0]  rset_i,
    input  logic               gie_i,
    input  logic               nmi_busy_i,
    input  logic               rsie_i,
    input  logic [LEVEL_W-1:0] cur_level_i,
    input  logic [RSET_W-1:0]  cur_rset_i,
    output logic               accept_o
);

    logic level_above;
    logic rset_switch;
    logic maskable_ok;

    always_comb begin
        level_above = level_i > cur_level_i;
        rset_switch = rset_i != cur_rset_i;
        maskable_ok = gie_i && level_above && (rset_switch || rsie_i);
        if (!valid_i) begin
            accept_o = 1'b0;
        end else if (nmi_i) begin
            accept_o = !nmi_busy_i;
        end else begin
            accept_o = maskable_ok;
        end
    end

endmodule

// File: rtl/irq_take_pulse.sv
module irq_take_pulse
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    output logic take_o
);

    pulse_state_t pulse_d, pulse_q;

    always_comb begin
        pulse_d.seen = accept_i;
        pulse_d.take = accept_i && !pulse_q.seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign take_o = pulse_q.take;

    // R4: a pulse follows an acceptance that was absent one cycle earlier
    assert_pulse_edge_R4: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(accept_i));

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter accept_mode_e MODE      = MODE_LINES,
    parameter int           NUM_LINES = 32,
    parameter int           LEVEL_W   = 6,
    parameter int           RSET_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    output logic [NUM_LINES-1:0] en_rdata,
    output logic [NUM_LINES-1:0] pend_rdata,
    input  logic                 req_valid,
    input  logic                 req_nmi,
    input  logic [LEVEL_W-1:0]   req_level,
    input  logic [RSET_W-1:0]    req_rset,
    input  logic                 st_gie,
    input  logic                 st_nmi_busy,
    input  logic                 st_rsie,
    input  logic [LEVEL_W-1:0]   st_level,
    input  logic [RSET_W-1:0]    st_crs,
    output logic                 take_irq,
    output logic                 work_pending
);

    logic accept;

    generate
        if (MODE == MODE_LINES) begin : g_lines
            logic bank_hit;
            logic unused_bundle;

            irq_line_bank #(
                .NUM_LINES(NUM_LINES)
            ) i_bank (
                .clk    (clk),
                .rst    (rst),
                .lines_i(irq_lines),
                .wr_i   (en_wr),
                .wdata_i(en_wdata),
                .pend_o (pend_rdata),
                .en_o   (en_rdata),
                .hit_o  (bank_hit)
            );

            assign accept        = st_gie && bank_hit;
            assign work_pending  = |pend_rdata;
            assign unused_bundle = ^{req_valid, req_nmi, req_level, req_rset,
                                     st_nmi_busy, st_rsie, st_level, st_crs};

            // R3: a pulse needs the global enable and an enabled pending line
            assert_line_gate_R3: assert property (@(posedge clk) disable iff (rst)
                take_irq |-> $past(st_gie) && ($past(pend_rdata & en_rdata) != '0));
        end else begin : g_bundle
            logic unused_lines;

            irq_bundle_judge #(
                .LEVEL_W(LEVEL_W),
                .RSET_W (RSET_W)
            ) i_judge (
                .valid_i    (req_valid),
                .nmi_i      (req_nmi),
                .level_i    (req_level),
                .rset_i     (req_rset),
                .gie_i      (st_gie),
                .nmi_busy_i (st_nmi_busy),
                .rsie_i     (st_rsie),
                .cur_level_i(st_level),
                .cur_rset_i (st_crs),
                .accept_o   (accept)
            );

            assign pend_rdata   = '0;
            assign en_rdata     = '0;
            assign work_pending = req_valid;
            assign unused_lines = ^{irq_lines, en_wr, en_wdata};

            // R5: a non-maskable take never happens while its handler runs
            assert_nmi_busy_R5: assert property (@(posedge clk) disable iff (rst)
                take_irq && $past(req_nmi) |-> !$past(st_nmi_busy));

            // R6: a maskable take needs the global enable
            assert_mask_gie_R6: assert property (@(posedge clk) disable iff (rst)
                take_irq && !$past(req_nmi) |-> $past(st_gie));

            // R7: a maskable take needs a strictly higher level
            assert_mask_level_R7: assert property (@(posedge clk) disable iff (rst)
                take_irq && !$past(req_nmi) |-> $past(req_level) > $past(st_level));

            // R8: re-entering the same register set needs the re-entry enable
            assert_same_rset_R8: assert property (@(posedge clk) disable iff (rst)
                take_irq && !$past(req_nmi) && ($past(req_rset) == $past(st_crs))
                |-> $past(st_rsie));
        end
    endgenerate

    irq_take_pulse i_pulse (
        .clk     (clk),
        .rst     (rst),
        .accept_i(accept),
        .take_o  (take_irq)
    );

    // R4: the take output never stays high two cycles in a row
    assert_take_single_R4: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> !take_irq);

    // R9: a take is always preceded by an active request
    assert_work_before_take_R9: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> $past(work_pending));

    // R10: the cycle after a reset the take output is low
    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> !take_irq);

endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
    import irq_accept_pkg::*;

    localparam int N  = 32;
    localparam int LW = 6;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_lines;
    logic          en_wr;
    logic [N-1:0]  en_wdata;
    logic          req_valid, req_nmi;
    logic [LW-1:0] req_level, st_level;
    logic [RW-1:0] req_rset, st_crs;
    logic          st_gie, st_nmi_busy, st_rsie;

    logic [N-1:0]  en_l, pend_l, en_b, pend_b;
    logic          take_l, work_l, take_b, work_b;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    irq_accept_unit #(.MODE(MODE_LINES)) i_irq_accept_unit (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .en_wr(en_wr),
        .en_wdata(en_wdata), .en_rdata(en_l), .pend_rdata(pend_l),
        .req_valid(req_valid), .req_nmi(req_nmi), .req_level(req_level),
        .req_rset(req_rset), .st_gie(st_gie), .st_nmi_busy(st_nmi_busy),
        .st_rsie(st_rsie), .st_level(st_level), .st_crs(st_crs),
        .take_irq(take_l), .work_pending(work_l)
    );

    irq_accept_unit #(.MODE(MODE_BUNDLE)) i_irq_accept_unit_ext (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .en_wr(en_wr),
        .en_wdata(en_wdata), .en_rdata(en_b), .pend_rdata(pend_b),
        .req_valid(req_valid), .req_nmi(req_nmi), .req_level(req_level),
        .req_rset(req_rset), .st_gie(st_gie), .st_nmi_busy(st_nmi_busy),
        .st_rsie(st_rsie), .st_level(st_level), .st_crs(st_crs),
        .take_irq(take_b), .work_pending(work_b)
    );

    typedef struct packed {
        logic          nmi;
        logic [LW-1:0] lvl;
        logic [RW-1:0] rs;
        logic          gie;
        logic          busy;
        logic          rsie;
        logic [LW-1:0] stl;
        logic [RW-1:0] crs;
        logic          exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd0,  6'd3, 1'b0, 1'b0, 1'b0, 6'd5,  6'd3, 1'b1},
        '{1'b1, 6'd9,  6'd1, 1'b1, 1'b1, 1'b1, 6'd2,  6'd2, 1'b0},
        '{1'b0, 6'd9,  6'd1, 1'b0, 1'b0, 1'b1, 6'd2,  6'd2, 1'b0},
        '{1'b0, 6'd3,  6'd1, 1'b1, 1'b0, 1'b1, 6'd3,  6'd2, 1'b0},
        '{1'b0, 6'd4,  6'd1, 1'b1, 1'b0, 1'b0, 6'd3,  6'd2, 1'b1},
        '{1'b0, 6'd4,  6'd2, 1'b1, 1'b0, 1'b0, 6'd3,  6'd2, 1'b0},
        '{1'b0, 6'd4,  6'd2, 1'b1, 1'b0, 1'b1, 6'd3,  6'd2, 1'b1},
        '{1'b0, 6'd63, 6'd0, 1'b1, 1'b0, 1'b1, 6'd62, 6'd0, 1'b1},
        '{1'b0, 6'd0,  6'd0, 1'b1, 1'b0, 1'b1, 6'd0,  6'd0, 1'b0},
        '{1'b0, 6'd5,  6'd4, 1'b1, 1'b1, 1'b0, 6'd1,  6'd2, 1'b1}
    };

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_en(input logic [N-1:0] v);
        @(negedge clk);
        en_wr    = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_wr    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_lines = '0; en_wr = 1'b0; en_wdata = '0;
        req_valid = 1'b0; req_nmi = 1'b0; req_level = '0; req_rset = '0;
        st_gie = 1'b0; st_nmi_busy = 1'b0; st_rsie = 1'b0;
        st_level = '0; st_crs = '0;
        repeat (3) tick();
        check("R10 reset take", take_l, 0);
        check("R10 reset pend", pend_l, 0);
        check("R10 reset en", en_l, 0);
        check("R9 reset work", work_l, 0);
        @(negedge clk);
        rst = 1'b0;

        // bundle form, table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1'b1;         req_nmi  = VECS[i].nmi;
            req_level = VECS[i].lvl;  req_rset = VECS[i].rs;
            st_gie    = VECS[i].gie;  st_nmi_busy = VECS[i].busy;
            st_rsie   = VECS[i].rsie; st_level = VECS[i].stl;
            st_crs    = VECS[i].crs;
            tick();
            check($sformatf("R5/R6/R7/R8 vector %0d take", i), take_b, VECS[i].exp);
            check($sformatf("R9 vector %0d work", i), work_b, 1);
            tick();
            check($sformatf("R4 vector %0d held", i), take_b, 0);
            @(negedge clk);
            req_valid = 1'b0;
            tick();
            check($sformatf("R9 vector %0d idle work", i), work_b, 0);
            tick();
        end

        // bundle form: accepting fields without a valid request
        @(negedge clk);
        req_nmi = 1'b1; st_nmi_busy = 1'b0; req_valid = 1'b0;
        tick();
        tick();
        check("R5 no valid no take", take_b, 0);
        req_nmi = 1'b0; st_gie = 1'b0;

        // line form
        write_en(32'h0000_0010);
        check("R2 enable readback", en_l, 32'h0000_0010);
        @(negedge clk);
        st_gie = 1'b1;
        irq_lines = 32'h0000_0001;
        tick();
        check("R1 pend follows line", pend_l, 32'h0000_0001);
        check("R9 work while blocked", work_l, 1);
        tick();
        check("R3 pending not enabled", take_l, 0);
        check("R2 enable held", en_l, 32'h0000_0010);

        @(negedge clk);
        st_gie = 1'b0;
        irq_lines = 32'h0000_0010;
        tick();
        check("R1 pend moves", pend_l, 32'h0000_0010);
        tick();
        check("R3 gie off", take_l, 0);

        @(negedge clk);
        st_gie = 1'b1;
        tick();
        check("R3 take on gie", take_l, 1);
        tick();
        check("R4 single pulse", take_l, 0);
        tick();
        check("R4 stays low", take_l, 0);

        @(negedge clk);
        irq_lines = '0;
        tick();
        check("R1 pend clears", pend_l, 0);
        check("R9 work clears", work_l, 0);

        write_en(32'h8000_0000);
        @(negedge clk);
        irq_lines = 32'h8000_0000;
        tick();
        check("R1 top line", pend_l, 32'h8000_0000);
        tick();
        check("R3 top line take", take_l, 1);

        @(negedge clk);
        rst = 1'b1;
        tick();
        check("R10 mid reset en", en_l, 0);
        check("R10 mid reset take", take_l, 0);
        @(negedge clk);
        rst = 1'b0;
        irq_lines = '0;
        tick();
        check("R1 after reset", pend_l, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule